// File: doc/BRIEF.md
# Synthesizer Lock Poller with One-Shot Recovery

This controller runs after a frequency synthesizer has been programmed. It waits for the synthesizer to report lock by reading a status byte through an indexed, byte-wide register bus. It makes one read per pacing interval and gives up after a fixed number of tries. The pacing interval is a parameter counted in clock cycles. It defaults to 1250 cycles, which is 10 µs at 125 MHz.

A caller pulses `start` and supplies two values: which synthesizer was programmed (pixel, loop or memory) and its VCO frequency in kHz. The loop-clock synthesizer can fail to lock at a high VCO frequency. For that case the controller makes a single repair attempt. It selects the loop synthesizer's P register and lowers its two-bit post-divider field by one when that field is nonzero. It then re-selects the status byte and polls a second full pass. When the controller finishes, `done` pulses for one cycle. `lock_err` reports whether lock was never seen.

The register bus has two ports. Port 0 is the index port and port 1 is the data port. The index values used during recovery, and the two selector bytes written to the synthesizer address register, are parameters.

Top module: `pll_lock_poller`

## Requirements
- R1: After a start is accepted, the controller reads the data port (bus_addr=1, bus_we=0) once per interval. The first read and each later read are requested no sooner than TICK_CYCLES cycles after the previous read (or the start) completes.
- R2: Lock is bit 6 of the byte read, and the other seven bits are ignored. When a read shows bit 6 set, done pulses, lock_err stays 0 and no further bus transaction is made.
- R3: A polling pass makes at most MAX_TRIES status reads. A lock seen on read number MAX_TRIES counts as success.
- R4: Recovery runs only when the first pass ends without lock, the selector is loop (code 1) and the VCO value is strictly greater than VCO_LIMIT_KHZ. Selector codes are: 0 pixel, 1 loop, 2 memory. With any other selector, or with a VCO value at or below the limit, an exhausted pass ends the run with lock_err=1.
- R5: Recovery issues these transactions in order: write index IDX_PLL_ADDR, write data SEL_LOOP_P (0xEA), write index IDX_LOOP_DATA, read data, write data (value-1) only if the value's bits [1:0] are nonzero, write index IDX_PLL_ADDR, write data SEL_STATUS (0xFF), write index IDX_LOOP_DATA.
- R6: After recovery, a second pass starts with the try count at zero. If it sees lock, lock_err=0. If it makes MAX_TRIES reads without lock, lock_err=1. There is never a second recovery.
- R7: bus_req stays high with bus_we, bus_addr and bus_wdata unchanged until bus_ack is sampled high. At most one transaction is outstanding.
- R8: done is high for exactly one cycle per run, with bus_req low. lock_err changes only as done rises, or to 0 when a start is accepted, and holds its value in between.
- R9: A start pulse during a run is ignored and does not change that run's selector, VCO value or outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lock wait (accepted only when idle) |
| pll_sel | input | 2 | Synthesizer selector: 0 pixel, 1 loop, 2 memory |
| vco_khz | input | VCO_W | VCO frequency in kHz, sampled with start |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 1 | 0 = index port, 1 = data port |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Bus acknowledge, completes the request |
| bus_rdata | input | 8 | Read byte, valid with bus_ack |
| done | output | 1 | One-cycle completion pulse |
| lock_err | output | 1 | Lock never seen; held until next accepted start |

## Verification
The bound checker watches, on every cycle, the bus hold rule, the single-cycle done pulse with the bus idle, and the rule that lock_err moves only as done rises or when a start is accepted. The bench scenarios are the only place where the decisions that depend on data can be seen. These are the choice between recovery and failure at the VCO boundary and for each selector, the exact recovery transaction list with and without the P write-back, the count of status reads in each pass, the spacing between reads, and immunity to a start pulse during a run. A slave model in the bench holds the index, the synthesizer address pointer and the loop P register, and presents status bytes whose other bits are noisy.

// File: rtl/pll_poll_pkg.sv
package pll_poll_pkg;

  typedef enum logic [1:0] {
    SEL_PIXEL = 2'd0,
    SEL_LOOP  = 2'd1,
    SEL_MEM   = 2'd2
  } pll_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_POLL,
    ST_R_PA1,
    ST_R_SELP,
    ST_R_LP1,
    ST_R_RD,
    ST_R_WB,
    ST_R_PA2,
    ST_R_SELS,
    ST_R_LP2
  } poll_state_e;

  typedef struct packed {
    logic       we;
    logic       addr;
    logic [7:0] wdata;
  } bus_cmd_t;

  localparam logic PORT_INDEX = 1'b0;
  localparam logic PORT_DATA  = 1'b1;
  localparam int   LOCK_BIT   = 6;

endpackage

// File: rtl/pll_tick_gen.sv
module pll_tick_gen #(
  parameter int TICK_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_try_ctr.sv
module pll_try_ctr #(
  parameter int MAX_TRIES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_TRIES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);
endmodule

// File: rtl/pll_bus_port.sv
module pll_bus_port
  import pll_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  bus_cmd_t   cmd,
  output logic       cmd_done,
  output logic [7:0] rsp_data,
  output logic       bus_req,
  output logic       bus_we,
  output logic       bus_addr,
  output logic [7:0] bus_wdata,
  input  logic       bus_ack,
  input  logic [7:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= 1'b0;
      bus_wdata <= '0;
      cmd_done  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (!bus_req && cmd_valid) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd.we;
        bus_addr  <= cmd.addr;
        bus_wdata <= cmd.wdata;
      end else if (bus_req && bus_ack) begin
        bus_req  <= 1'b0;
        cmd_done <= 1'b1;
        rsp_data <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/pll_lock_poller.sv
module pll_lock_poller
  import pll_poll_pkg::*;
#(
  parameter int         TICK_CYCLES   = 1250,
  parameter int         MAX_TRIES     = 5000,
  parameter int         VCO_W         = 32,
  parameter int         VCO_LIMIT_KHZ = 180000,
  parameter logic [7:0] IDX_PLL_ADDR  = 8'h2C,
  parameter logic [7:0] IDX_LOOP_DATA = 8'h2F,
  parameter logic [7:0] SEL_LOOP_P    = 8'hEA,
  parameter logic [7:0] SEL_STATUS    = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       pll_sel,
  input  logic [VCO_W-1:0] vco_khz,
  output logic             bus_req,
  output logic             bus_we,
  output logic             bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             done,
  output logic             lock_err
);
  localparam logic [VCO_W-1:0] VCO_LIMIT = VCO_W'(VCO_LIMIT_KHZ);

  poll_state_e state;
  logic        issued;
  logic        second_pass;
  logic        may_recover;
  logic [7:0]  p_val;

  logic        tick;
  logic        at_last;
  logic        try_clr;
  logic        try_inc;
  logic        cmd_valid;
  logic        cmd_done;
  logic [7:0]  rsp_data;
  logic        bus_state;
  logic        locked_rd;
  bus_cmd_t    cmd;

  pll_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (state == ST_WAIT),
    .tick(tick)
  );

  pll_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk    (clk),
    .rst    (rst),
    .clr    (try_clr),
    .inc    (try_inc),
    .at_last(at_last)
  );

  pll_bus_port u_bus (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd      (cmd),
    .cmd_done (cmd_done),
    .rsp_data (rsp_data),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata)
  );

  // Command for the current bus-issuing state
  always_comb begin
    bus_state = 1'b1;
    cmd       = '{we: 1'b1, addr: PORT_INDEX, wdata: 8'h00};
    unique case (state)
      ST_POLL:   cmd = '{we: 1'b0, addr: PORT_DATA,  wdata: 8'h00};
      ST_R_PA1:  cmd = '{we: 1'b1, addr: PORT_INDEX, wdata: IDX_PLL_ADDR};
      ST_R_SELP: cmd = '{we: 1'b1, addr: PORT_DATA,  wdata: SEL_LOOP_P};
      ST_R_LP1:  cmd = '{we: 1'b1, addr: PORT_INDEX, wdata: IDX_LOOP_DATA};
      ST_R_RD:   cmd = '{we: 1'b0, addr: PORT_DATA,  wdata: 8'h00};
      ST_R_WB:   cmd = '{we: 1'b1, addr: PORT_DATA,  wdata: p_val - 8'd1};
      ST_R_PA2:  cmd = '{we: 1'b1, addr: PORT_INDEX, wdata: IDX_PLL_ADDR};
      ST_R_SELS: cmd = '{we: 1'b1, addr: PORT_DATA,  wdata: SEL_STATUS};
      ST_R_LP2:  cmd = '{we: 1'b1, addr: PORT_INDEX, wdata: IDX_LOOP_DATA};
      default:   bus_state = 1'b0;
    endcase
  end

  assign cmd_valid = bus_state && !issued;
  assign locked_rd = rsp_data[LOCK_BIT];
  assign try_clr   = ((state == ST_IDLE) && start) ||
                     ((state == ST_R_LP2) && cmd_done);
  assign try_inc   = (state == ST_POLL) && cmd_done && !locked_rd && !at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      issued      <= 1'b0;
      second_pass <= 1'b0;
      may_recover <= 1'b0;
      p_val       <= '0;
      done        <= 1'b0;
      lock_err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_valid)     issued <= 1'b1;
      else if (cmd_done) issued <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lock_err    <= 1'b0;
            second_pass <= 1'b0;
            may_recover <= (pll_sel == SEL_LOOP) && (vco_khz > VCO_LIMIT);
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: if (tick) state <= ST_POLL;
        ST_POLL: begin
          if (cmd_done) begin
            if (locked_rd) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (!at_last) begin
              state <= ST_WAIT;
            end else if (!second_pass && may_recover) begin
              state <= ST_R_PA1;
            end else begin
              done     <= 1'b1;
              lock_err <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        ST_R_PA1:  if (cmd_done) state <= ST_R_SELP;
        ST_R_SELP: if (cmd_done) state <= ST_R_LP1;
        ST_R_LP1:  if (cmd_done) state <= ST_R_RD;
        ST_R_RD: begin
          if (cmd_done) begin
            p_val <= rsp_data;
            state <= (rsp_data[1:0] != 2'b00) ? ST_R_WB : ST_R_PA2;
          end
        end
        ST_R_WB:   if (cmd_done) state <= ST_R_PA2;
        ST_R_PA2:  if (cmd_done) state <= ST_R_SELS;
        ST_R_SELS: if (cmd_done) state <= ST_R_LP2;
        ST_R_LP2: begin
          if (cmd_done) begin
            second_pass <= 1'b1;
            state       <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_lock_poller_chk.sv
module pll_lock_poller_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       done,
  input logic       lock_err,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       bus_we,
  input logic       bus_addr,
  input logic [7:0] bus_wdata
);
  // R7: request and its fields hold until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                               $stable(bus_addr) && $stable(bus_wdata)));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8 / R2: completion only with the bus idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

  // R8: error only appears together with done
  p_err_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_err) |-> done);

  // R8: error only clears because a start was presented
  p_err_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_err) |-> $past(start));
endmodule

bind pll_lock_poller pll_lock_poller_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .lock_err (lock_err),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/tb_pll_lock_poller.sv
module tb_pll_lock_poller;
  localparam int TICK = 6;
  localparam int MAXT = 8;
  localparam int LIM  = 180000;
  localparam logic [7:0] IPA = 8'h2C;
  localparam logic [7:0] ILP = 8'h2F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] pll_sel = 2'd0;
  logic [31:0] vco_khz = '0;
  logic bus_req, bus_we, bus_addr;
  logic [7:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [7:0] bus_rdata = '0;
  logic done, lock_err;

  always #4 clk = ~clk;

  pll_lock_poller #(
    .TICK_CYCLES(TICK), .MAX_TRIES(MAXT), .VCO_W(32), .VCO_LIMIT_KHZ(LIM),
    .IDX_PLL_ADDR(IPA), .IDX_LOOP_DATA(ILP), .SEL_LOOP_P(8'hEA), .SEL_STATUS(8'hFF)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .pll_sel(pll_sel), .vco_khz(vco_khz),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .lock_err(lock_err)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // slave model state
  logic [7:0] s_idx = 8'h00;
  logic [7:0] s_ptr = 8'hFF;
  logic [7:0] s_loop = 8'h00;
  int s_la1 = 0, s_la2 = 0, s_pass_rd = 0, s_status_rd = 0;
  bit s_pass2 = 0, s_noise_all = 0;
  int s_wait = 0, s_last = 0, s_min_gap = 0;
  int wcnt = 0;
  logic wl_addr [16];
  logic [7:0] wl_data [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // bus slave: acks on the falling edge after a random delay
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (s_wait > 0) s_wait--;
      else begin
        if (bus_we) begin
          if (wcnt < 16) begin wl_addr[wcnt] = bus_addr; wl_data[wcnt] = bus_wdata; end
          wcnt++;
          if (!bus_addr) s_idx = bus_wdata;
          else if (s_idx == IPA) s_ptr = bus_wdata;
          else if (s_idx == ILP) s_loop = bus_wdata;
        end else if (bus_addr && s_idx == ILP && s_ptr == 8'hEA) begin
          bus_rdata = s_loop;
          s_pass2 = 1;
          s_pass_rd = 0;
        end else begin
          int la;
          logic [7:0] nz;
          s_status_rd++;
          s_pass_rd++;
          if (cyc - s_last < s_min_gap) s_min_gap = cyc - s_last;
          la = s_pass2 ? s_la2 : s_la1;
          nz = s_noise_all ? 8'hFF : 8'($urandom);
          nz[6] = (la != 0 && s_pass_rd >= la);
          bus_rdata = nz;
        end
        if (bus_we || !bus_addr || s_idx != ILP || s_ptr != 8'hEA) s_last = cyc;
        bus_ack = 1'b1;
        s_wait = int'($urandom % 4);
      end
    end
  end

  function automatic bit in_rng(input int la);
    return (la >= 1 && la <= MAXT);
  endfunction

  task automatic run(input logic [1:0] sel, input logic [31:0] vco, input int la1,
                     input int la2, input logic [7:0] pinit, input bit glitch,
                     input string tag);
    bit recov;
    int exp_reads, exp_w;
    bit exp_err;
    logic [7:0] pexp;
    int guard;
    s_la1 = la1; s_la2 = la2; s_loop = pinit; s_pass2 = 0; s_pass_rd = 0;
    s_status_rd = 0; wcnt = 0; s_ptr = 8'hFF; s_idx = 8'h00; s_min_gap = 1 << 30;
    @(negedge clk);
    start = 1'b1; pll_sel = sel; vco_khz = vco;
    @(negedge clk);
    start = 1'b0;
    s_last = cyc;
    chk(lock_err == 1'b0, {"R8 err cleared on start ", tag}, int'(lock_err), 0);
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (glitch && guard == 10) begin
        start = 1'b1; pll_sel = 2'd1; vco_khz = 32'd250000;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    recov = (sel == 2'd1) && (vco > LIM) && !in_rng(la1);
    if (in_rng(la1))      begin exp_reads = la1;        exp_err = 0; end
    else if (!recov)      begin exp_reads = MAXT;       exp_err = 1; end
    else if (in_rng(la2)) begin exp_reads = MAXT + la2; exp_err = 0; end
    else                  begin exp_reads = 2 * MAXT;   exp_err = 1; end
    pexp = (recov && pinit[1:0] != 2'b00) ? pinit - 8'd1 : pinit;
    exp_w = recov ? ((pinit[1:0] != 2'b00) ? 7 : 6) : 0;
    chk(done == 1'b1, {"R8 done seen ", tag}, int'(done), 1);
    chk(lock_err == exp_err, {"R2/R3/R6 lock_err ", tag}, int'(lock_err), int'(exp_err));
    chk(s_status_rd == exp_reads, {"R3/R6 status reads ", tag}, s_status_rd, exp_reads);
    chk(wcnt == exp_w, {"R4/R5 write count ", tag}, wcnt, exp_w);
    chk(s_loop == pexp, {"R5 loop P value ", tag}, int'(s_loop), int'(pexp));
    chk(s_min_gap >= TICK, {"R1 read spacing ", tag}, s_min_gap, TICK);
    if (recov && wcnt == exp_w) begin
      logic [8:0] seq [7];
      int k = 0;
      seq[k++] = {1'b0, IPA};
      seq[k++] = {1'b1, 8'hEA};
      seq[k++] = {1'b0, ILP};
      if (pinit[1:0] != 2'b00) seq[k++] = {1'b1, pinit - 8'd1};
      seq[k++] = {1'b0, IPA};
      seq[k++] = {1'b1, 8'hFF};
      seq[k++] = {1'b0, ILP};
      for (int i = 0; i < k; i++)
        chk({wl_addr[i], wl_data[i]} == seq[i], {"R5 recovery order ", tag},
            int'({wl_addr[i], wl_data[i]}), int'(seq[i]));
    end
    @(negedge clk);
    chk(done == 1'b0, {"R8 done single cycle ", tag}, int'(done), 0);
    chk(bus_req == 1'b0, {"R2 no bus after done ", tag}, int'(bus_req), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && lock_err == 1'b0 && bus_req == 1'b0, "R8 reset state",
        int'({done, lock_err, bus_req}), 0);

    run(2'd0, 32'd100000, 3, 0, 8'h00, 0, "R1 R2 pixel lock");
    run(2'd2, 32'd90000, MAXT, 0, 8'h00, 0, "R3 lock on last try");
    run(2'd0, 32'd200000, 0, 0, 8'h03, 0, "R3 pixel timeout");
    repeat (30) @(negedge clk);
    chk(lock_err == 1'b1, "R8 error held", int'(lock_err), 1);
    s_noise_all = 1;
    run(2'd0, 32'd100000, 0, 0, 8'h00, 0, "R2 noise bits ignored");
    run(2'd0, 32'd100000, 2, 0, 8'h00, 0, "R2 lock with noise");
    s_noise_all = 0;
    run(2'd1, 32'd180000, 0, 0, 8'hF3, 0, "R4 at limit no recovery");
    run(2'd2, 32'd250000, 0, 0, 8'hF3, 0, "R4 memory no recovery");
    run(2'd1, 32'd180001, 0, 0, 8'hF3, 0, "R5 R6 recovery then fail");
    run(2'd1, 32'd200000, 0, 2, 8'hF2, 0, "R6 recovery then lock");
    run(2'd1, 32'd200000, 0, MAXT, 8'hF0, 0, "R5 zero P no writeback");
    run(2'd0, 32'd100000, 0, 0, 8'h01, 1, "R9 start while busy");

    for (int n = 0; n < 25; n++) begin
      logic [1:0] sel = 2'($urandom % 3);
      logic [31:0] vco = 32'd170000 + 32'($urandom % 20000);
      int a1 = int'($urandom % (MAXT + 3));
      int a2 = int'($urandom % (MAXT + 3));
      run(sel, vco, a1, a2, 8'($urandom), 0, "R1-random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule